// File: doc/BRIEF.md
# Two-bit branch direction predictor

This block guesses the direction of conditional branches at fetch time. A direct-mapped table of two-bit entries is indexed by the fetch address, and the entry selected by the current fetch address gives a taken or not-taken guess in the same cycle. The two low address bits are dropped from the index because instructions are word aligned. No tag is checked, so addresses that share index bits share an entry.

Each entry holds a direction bit and a "last guess was wrong" bit. When a branch resolves, the pipeline presents the branch address and the real outcome on the training port. The entry at that index then moves one step. A correct outcome clears the wrong bit. A first wrong outcome sets the wrong bit. A second wrong outcome in a row reverses the direction and clears the wrong bit. Because of this, the guessed direction changes only after two consecutive mispredictions. The default table has 4096 entries.

Top module: `bht_predictor`

## Requirements
- R1: After reset, every entry guesses not-taken (pred_taken = 0) and is marked as last guess right. Entry encoding is {direction, wrong}: direction 1 = taken, wrong 1 = last guess wrong. Reset value is 00.
- R2: pred_taken is combinational and equals the direction bit of the entry selected by fetch_pc bits [IDX_W+1:2].
- R3: Address bits [1:0], and bits above IDX_W+1, take no part in selecting an entry. Addresses that differ only in those bits read and train the same entry.
- R4: A training outcome that matches the entry's direction keeps the direction and sets the wrong bit to 0.
- R5: A training outcome that differs from the direction, when the wrong bit is 0, keeps the direction and sets the wrong bit to 1.
- R6: A training outcome that differs from the direction, when the wrong bit is 1, reverses the direction and sets the wrong bit to 0.
- R7: A training write becomes visible on pred_taken from the following cycle. A lookup in the same cycle sees the entry's old value, even when the index is the same.
- R8: When upd_valid is 0, the training port has no effect on any entry.
- R9: A training write changes only the entry at its own index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_taken | output | 1 | Direction guess for fetch_pc |
| upd_valid | input | 1 | Training strobe for a resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The assertions assume that upd_pc and upd_taken are known (not X) whenever upd_valid is high. They also assume that the training port presents at most one branch per cycle. The stimulus drives every input to a defined value on every cycle, including the reset cycles, where upd_valid is held low. The training addresses in the random stream come from a small set of indices plus alias offsets in bits [1:0] and in the upper bits. This makes back-to-back mispredictions on one entry, and same-cycle lookups of the entry being trained, happen often.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // One table entry: guessed direction plus "last guess was wrong" flag.
    typedef struct packed {
        logic dir;    // 1 = taken
        logic wrong;  // 1 = previous guess was wrong
    } bht_ent_t;

    localparam bht_ent_t BHT_ENT_RESET = '{dir: 1'b0, wrong: 1'b0};

endpackage

// File: rtl/bht_pc_index.sv
module bht_pc_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Word-aligned fetch: the two byte-offset bits never select an entry.
    localparam int LO = 2;

    always_comb begin
        idx = pc[LO +: IDX_W];
    end
endmodule

// File: rtl/bht_ent_update.sv
module bht_ent_update
    import bht_pkg::*;
(
    input  bht_ent_t cur,
    input  logic     taken,
    output bht_ent_t nxt
);
    always_comb begin
        nxt = cur;
        if (taken == cur.dir) begin
            nxt.wrong = 1'b0;
        end else if (!cur.wrong) begin
            nxt.wrong = 1'b1;
        end else begin
            nxt.dir   = ~cur.dir;
            nxt.wrong = 1'b0;
        end
    end
endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output bht_ent_t         rd_ent,
    input  logic [IDX_W-1:0] wr_idx,
    output bht_ent_t         wr_old,
    input  logic             wr_en,
    input  bht_ent_t         wr_ent
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        bht_ent_t [ENTRIES-1:0] ent;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ent[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= {ENTRIES{BHT_ENT_RESET}};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_ent = state_q.ent[rd_idx];
        wr_old = state_q.ent[wr_idx];
    end

    // R7: a write is present in the table one cycle later
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q.ent[$past(wr_idx)] == $past(wr_ent));

    // R8: without a write strobe the addressed entry is untouched
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> state_q.ent[$past(wr_idx)] == $past(wr_old));

    // R9: an entry at an index other than the write index is untouched
    p_other_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx != wr_idx) |=> state_q.ent[$past(rd_idx)] == $past(rd_ent));
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    bht_ent_t         fetch_ent;
    bht_ent_t         upd_old;
    bht_ent_t         upd_new;

    bht_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_idx (
        .pc  (fetch_pc),
        .idx (fetch_idx)
    );

    bht_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bht_ent_update u_step (
        .cur   (upd_old),
        .taken (upd_taken),
        .nxt   (upd_new)
    );

    bht_table #(.IDX_W(IDX_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fetch_idx),
        .rd_ent (fetch_ent),
        .wr_idx (upd_idx),
        .wr_old (upd_old),
        .wr_en  (upd_valid),
        .wr_ent (upd_new)
    );

    always_comb begin
        pred_taken = fetch_ent.dir;
    end

    // R4: a correct outcome keeps the direction and clears the wrong flag
    p_hit_keeps_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken == upd_old.dir) |=>
        (u_tbl.state_q.ent[$past(upd_idx)].dir == $past(upd_old.dir)) &&
        !u_tbl.state_q.ent[$past(upd_idx)].wrong);

    // R5: a first miss keeps the direction and raises the wrong flag
    p_first_miss_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken != upd_old.dir && !upd_old.wrong) |=>
        (u_tbl.state_q.ent[$past(upd_idx)].dir == $past(upd_old.dir)) &&
        u_tbl.state_q.ent[$past(upd_idx)].wrong);

    // R6: a second consecutive miss reverses the direction
    p_second_miss_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken != upd_old.dir && upd_old.wrong) |=>
        (u_tbl.state_q.ent[$past(upd_idx)].dir == $past(upd_taken)) &&
        !u_tbl.state_q.ent[$past(upd_idx)].wrong);
endmodule

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb;
    localparam int PC_W  = 32;
    localparam int IDX_W = 12;
    localparam int IMASK = (1 << IDX_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    typedef struct {
        logic  exp;
        string req;
        logic [PC_W-1:0] pc;
    } sb_item_t;

    sb_item_t   sb_q[$];
    logic [1:0] mdl [int];   // {dir, wrong}
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    function automatic int pidx(logic [PC_W-1:0] pc);
        return int'((pc >> 2) & IMASK);
    endfunction

    function automatic logic [1:0] mget(int i);
        if (mdl.exists(i)) return mdl[i];
        return 2'b00;
    endfunction

    // One cycle: drive lookup and training, queue expected guess (old table), train model.
    task automatic step(input logic [PC_W-1:0] fpc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut, input string req);
        sb_item_t it;
        logic [1:0] e;
        @(negedge clk);
        fetch_pc  = fpc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        it.exp = mget(pidx(fpc))[1];
        it.req = req;
        it.pc  = fpc;
        sb_q.push_back(it);
        if (uv) begin
            e = mget(pidx(upc));
            if (ut == e[1])      e = {e[1], 1'b0};
            else if (!e[0])      e = {e[1], 1'b1};
            else                 e = {ut, 1'b0};
            mdl[pidx(upc)] = e;
        end
    endtask

    task automatic look(input logic [PC_W-1:0] fpc, input string req);
        step(fpc, 1'b0, 32'h0, 1'b0, req);
    endtask

    task automatic train(input logic [PC_W-1:0] upc, input logic ut, input string req);
        step(upc, 1'b1, upc, ut, req);
    endtask

    // Monitor: samples shortly before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (pred_taken !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s pc=%h actual=%b expected=%b", it.req, it.pc, pred_taken, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [PC_W-1:0] A = 32'h0000_1040;
    localparam logic [PC_W-1:0] B = 32'h0000_1044; // neighbour index

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state guesses not-taken everywhere
        look(32'h0, "R1");
        look(32'h0000_3FFC, "R1");
        look(A, "R1");

        // R8: strobeless training does nothing (neither dir nor wrong flag)
        step(A, 1'b0, A, 1'b1, "R8");
        step(A, 1'b0, A, 1'b1, "R8");
        look(A, "R8");
        // R5: first miss keeps direction; R7: same-cycle lookup sees old value
        train(A, 1'b1, "R7");
        look(A, "R5");
        // R6: second consecutive miss reverses
        train(A, 1'b1, "R6");
        look(A, "R6");
        // R9: neighbour untouched
        look(B, "R9");
        // R4: correct outcome clears wrong flag, then single miss must not flip
        train(A, 1'b0, "R5");
        train(A, 1'b1, "R4");
        train(A, 1'b0, "R4");
        look(A, "R4");
        train(A, 1'b0, "R6");
        look(A, "R6");
        // R3: alias via low bits and upper bits
        train(A, 1'b1, "R3");
        train(A | 32'h3, 1'b1, "R3");
        look(A | 32'h1, "R3");
        look(A + (32'h1 << (IDX_W + 2)), "R3");
        look(B, "R9");

        // R2: random mix across a few indices with aliases
        for (int i = 0; i < 400; i++) begin
            logic [PC_W-1:0] p, f;
            p = (32'h1000 + (($urandom % 6) << 2)) | ($urandom % 4) |
                (($urandom % 3) << (IDX_W + 2));
            f = (32'h1000 + (($urandom % 6) << 2)) | (($urandom % 2) << (IDX_W + 2));
            step(f, 1'($urandom % 4 != 0), p, 1'($urandom % 2), "R2");
        end
        look(A, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule